// File: doc/BRIEF.md
# Vector instruction expansion unit

This block sits between instruction decode and an instruction FIFO. It accepts one decoded scalar arithmetic instruction at a time. Each instruction carries an opcode, a destination register number and two source register numbers. The block looks up all three registers in a per-register vector-length table and replays the instruction into the FIFO as a series of scalar instructions, one per element. No parallel hardware is needed: the block issues the elements one after another, one per push.

A register whose table entry is non-zero counts as vectorised. In element `i` it is replaced by register `base+i`. A register whose entry is zero stays fixed in every generated instruction. For example, with r4 set to three elements and r2 left scalar, `ADD r2,r4,r4` becomes `ADD r2,r4,r4`, `ADD r2,r5,r5`, `ADD r2,r6,r6`. While an expansion is running the input is held off. When the FIFO is full the sequence stalls without losing or repeating an element.

Top module: `vec_expand`

## Requirements
- R1: An accepted instruction produces N pushes, where N is the largest table entry among its vectorised operands. When no operand is vectorised, exactly one push is made and it carries the input unchanged.
- R2: A register is vectorised when its 4-bit table entry is non-zero. A register whose entry is zero keeps its number in every push.
- R3: In push number i (counting from 0), each vectorised operand carries register number base+i.
- R4: The pushes come out in element order. The first push is raised in the cycle after acceptance, and each following push comes in the cycle after the previous one is taken (push_o high while full_i is low).
- R5: in_ready_o is low from the cycle after acceptance until the cycle after the last push is taken. An instruction is accepted only on a cycle where in_valid_i and in_ready_o are both high.
- R6: While full_i is high, push_o stays high and every output field stays the same. No element is dropped or duplicated.
- R7: If base+i goes past the highest register index, the number wraps modulo the register count. wrap_err_o rises in the cycle after such an element is taken and stays high until reset.
- R8: A table write made on a clock edge affects only instructions accepted on later edges. It never changes an expansion that is already in progress.
- R9: After reset, in_ready_o is 1, push_o is 0, wrap_err_o is 0 and every table entry is 0, so all registers are scalar.
- R10: Every push of an expansion carries the opcode of the accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write enable |
| cfg_reg_i | input | REG_W | Register whose length entry is written |
| cfg_len_i | input | LEN_W | New length entry (0 = scalar) |
| in_valid_i | input | 1 | Decoded instruction valid |
| in_ready_o | output | 1 | Ready to accept an instruction |
| in_op_i | input | OP_W | Opcode |
| in_rd_i | input | REG_W | Destination register |
| in_rs1_i | input | REG_W | First source register |
| in_rs2_i | input | REG_W | Second source register |
| push_o | output | 1 | FIFO push request |
| full_i | input | 1 | FIFO full; the push is not taken |
| out_op_o | output | OP_W | Opcode of the current element |
| out_rd_o | output | REG_W | Destination of the current element |
| out_rs1_o | output | REG_W | First source of the current element |
| out_rs2_o | output | REG_W | Second source of the current element |
| wrap_err_o | output | 1 | Sticky register wrap flag |

## Verification
Acceptance happens on the edge where in_valid_i and in_ready_o are both high. The first element is due on push_o one cycle later. Each further element is due one cycle after the previous one is taken, and in_ready_o returns one cycle after the last one is taken. wrap_err_o is due one cycle after a wrapping element is taken. A table write is seen only by instructions accepted on a later edge. The bench holds a queue of expected elements that is filled on the acceptance edge and popped on each taken edge. At every falling clock edge it compares push_o, in_ready_o, the output fields and the error flag against that queue, so each result is checked in exactly the cycle it is due, with FIFO full toggled at random.

// File: rtl/vx_pkg.sv
package vx_pkg;
  localparam int unsigned NUM_OPS = 3;
  typedef enum int unsigned {OPD_RD = 0, OPD_RS1 = 1, OPD_RS2 = 2} opd_e;
endpackage

// File: rtl/vx_len_table.sv
module vx_len_table #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned NRD   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [REG_W-1:0]          wa_i,
  input  logic [LEN_W-1:0]          wd_i,
  input  logic [NRD-1:0][REG_W-1:0] ra_i,
  output logic [NRD-1:0][LEN_W-1:0] rd_o
);
  localparam int unsigned NREG = 1 << REG_W;

  logic [NREG-1:0][LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else if (we_i) len_q[wa_i] <= wd_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_o[p] = len_q[ra_i[p]];
  end
endmodule

// File: rtl/vx_seq.sv
module vx_seq
  import vx_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned OP_W  = 7
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic                          full_i,
  input  logic [OP_W-1:0]               in_op_i,
  input  logic [NUM_OPS-1:0][REG_W-1:0] in_regs_i,
  input  logic [NUM_OPS-1:0][LEN_W-1:0] in_lens_i,
  output logic                          busy_o,
  output logic [OP_W-1:0]               op_o,
  output logic [NUM_OPS-1:0][REG_W-1:0] regs_o,
  output logic [NUM_OPS-1:0]            vec_o,
  output logic [LEN_W-1:0]              idx_o
);
  logic             busy_q;
  logic [LEN_W-1:0] idx_q, last_q, max_len, last_d;
  logic             accept, take;

  // longest vector among operands; zero entries mean scalar
  always_comb begin
    max_len = '0;
    for (int p = 0; p < int'(NUM_OPS); p++)
      if (in_lens_i[p] > max_len) max_len = in_lens_i[p];
    last_d = (max_len == '0) ? '0 : max_len - 1'b1;
  end

  assign accept = in_valid_i && !busy_q;
  assign take   = busy_q && !full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      op_o   <= '0;
      regs_o <= '0;
      vec_o  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      last_q <= last_d;
      op_o   <= in_op_i;
      regs_o <= in_regs_i;
      for (int p = 0; p < int'(NUM_OPS); p++) vec_o[p] <= (in_lens_i[p] != '0);
    end else if (take) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/vx_opgen.sv
module vx_opgen #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned LEN_W = 4
) (
  input  logic [REG_W-1:0] base_i,
  input  logic             vec_i,
  input  logic [LEN_W-1:0] idx_i,
  output logic [REG_W-1:0] reg_o,
  output logic             wrap_o
);
  localparam int unsigned SUM_W = REG_W + LEN_W + 1;

  logic [SUM_W-1:0] sum;

  assign sum    = SUM_W'(base_i) + (vec_i ? SUM_W'(idx_i) : '0);
  assign reg_o  = sum[REG_W-1:0];
  assign wrap_o = |sum[SUM_W-1:REG_W];
endmodule

// File: rtl/vec_expand.sv
module vec_expand
  import vx_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned OP_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_reg_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [OP_W-1:0]  in_op_i,
  input  logic [REG_W-1:0] in_rd_i,
  input  logic [REG_W-1:0] in_rs1_i,
  input  logic [REG_W-1:0] in_rs2_i,
  output logic             push_o,
  input  logic             full_i,
  output logic [OP_W-1:0]  out_op_o,
  output logic [REG_W-1:0] out_rd_o,
  output logic [REG_W-1:0] out_rs1_o,
  output logic [REG_W-1:0] out_rs2_o,
  output logic             wrap_err_o
);
  logic [NUM_OPS-1:0][REG_W-1:0] in_regs, base_regs, out_regs;
  logic [NUM_OPS-1:0][LEN_W-1:0] in_lens;
  logic [NUM_OPS-1:0]            vec, wrap;
  logic [LEN_W-1:0]              idx;
  logic                          busy, err_q;

  assign in_regs[OPD_RD]  = in_rd_i;
  assign in_regs[OPD_RS1] = in_rs1_i;
  assign in_regs[OPD_RS2] = in_rs2_i;

  vx_len_table #(.REG_W(REG_W), .LEN_W(LEN_W), .NRD(NUM_OPS)) u_tbl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .wa_i  (cfg_reg_i),
    .wd_i  (cfg_len_i),
    .ra_i  (in_regs),
    .rd_o  (in_lens)
  );

  vx_seq #(.REG_W(REG_W), .LEN_W(LEN_W), .OP_W(OP_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid_i),
    .full_i    (full_i),
    .in_op_i   (in_op_i),
    .in_regs_i (in_regs),
    .in_lens_i (in_lens),
    .busy_o    (busy),
    .op_o      (out_op_o),
    .regs_o    (base_regs),
    .vec_o     (vec),
    .idx_o     (idx)
  );

  for (genvar p = 0; p < NUM_OPS; p++) begin : g_opd
    vx_opgen #(.REG_W(REG_W), .LEN_W(LEN_W)) u_gen (
      .base_i(base_regs[p]),
      .vec_i (vec[p]),
      .idx_i (idx),
      .reg_o (out_regs[p]),
      .wrap_o(wrap[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (busy && !full_i && |wrap) err_q <= 1'b1;
  end

  assign in_ready_o = !busy;
  assign push_o     = busy;
  assign out_rd_o   = out_regs[OPD_RD];
  assign out_rs1_o  = out_regs[OPD_RS1];
  assign out_rs2_o  = out_regs[OPD_RS2];
  assign wrap_err_o = err_q;
endmodule

// File: rtl/vx_expand_chk.sv
module vx_expand_chk #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned OP_W  = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [REG_W-1:0] cfg_reg_i,
  input logic [LEN_W-1:0] cfg_len_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [OP_W-1:0]  in_op_i,
  input logic [REG_W-1:0] in_rd_i,
  input logic [REG_W-1:0] in_rs1_i,
  input logic [REG_W-1:0] in_rs2_i,
  input logic             push_o,
  input logic             full_i,
  input logic [OP_W-1:0]  out_op_o,
  input logic [REG_W-1:0] out_rd_o,
  input logic [REG_W-1:0] out_rs1_o,
  input logic [REG_W-1:0] out_rs2_o,
  input logic             wrap_err_o
);
  // R5
  busy_blocks_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !in_ready_o);

  // R4
  accept_then_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> push_o);

  // R5
  idle_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> in_ready_o && !push_o);

  // R6
  stall_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o && full_i |=> push_o && $stable(out_op_o) && $stable(out_rd_o)
                         && $stable(out_rs1_o) && $stable(out_rs2_o));

  // R10
  op_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o && $past(push_o) |-> $stable(out_op_o));

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_err_o |=> wrap_err_o);
endmodule

bind vec_expand vx_expand_chk #(.REG_W(REG_W), .LEN_W(LEN_W), .OP_W(OP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_we_i  (cfg_we_i),
  .cfg_reg_i (cfg_reg_i),
  .cfg_len_i (cfg_len_i),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .in_op_i   (in_op_i),
  .in_rd_i   (in_rd_i),
  .in_rs1_i  (in_rs1_i),
  .in_rs2_i  (in_rs2_i),
  .push_o    (push_o),
  .full_i    (full_i),
  .out_op_o  (out_op_o),
  .out_rd_o  (out_rd_o),
  .out_rs1_o (out_rs1_o),
  .out_rs2_o (out_rs2_o),
  .wrap_err_o(wrap_err_o)
);

// File: tb/test_vec_expand.sv
`timescale 1ns/1ps
module test_vec_expand;
  localparam int REG_W = 5;
  localparam int LEN_W = 4;
  localparam int OP_W  = 7;
  localparam int NREG  = 1 << REG_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [REG_W-1:0] cfg_reg_i = '0;
  logic [LEN_W-1:0] cfg_len_i = '0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [OP_W-1:0]  in_op_i = '0;
  logic [REG_W-1:0] in_rd_i = '0, in_rs1_i = '0, in_rs2_i = '0;
  logic             push_o;
  logic             full_i = 1'b0;
  logic [OP_W-1:0]  out_op_o;
  logic [REG_W-1:0] out_rd_o, out_rs1_o, out_rs2_o;
  logic             wrap_err_o;

  always #5 clk = ~clk;

  vec_expand #(.REG_W(REG_W), .LEN_W(LEN_W), .OP_W(OP_W)) i_vec_expand (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_reg_i(cfg_reg_i), .cfg_len_i(cfg_len_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_op_i(in_op_i),
    .in_rd_i(in_rd_i), .in_rs1_i(in_rs1_i), .in_rs2_i(in_rs2_i),
    .push_o(push_o), .full_i(full_i), .out_op_o(out_op_o),
    .out_rd_o(out_rd_o), .out_rs1_o(out_rs1_o), .out_rs2_o(out_rs2_o),
    .wrap_err_o(wrap_err_o)
  );

  typedef struct {
    int op, rd, rs1, rs2;
    bit wrap;
  } elem_t;

  elem_t q[$];
  int    tbl[NREG];
  bit    m_err = 1'b0;
  int    n_chk = 0, n_bad = 0;
  bit    bp_on = 1'b0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int stepped(int base, int len, int i, output bit w);
    w = 1'b0;
    if (len == 0) return base;
    w = (base + i) >= NREG;
    return (base + i) % NREG;
  endfunction

  // reference model: expansion on accept, pop on taken push, then table write
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      m_err = 1'b0;
      for (int r = 0; r < NREG; r++) tbl[r] = 0;
    end else begin
      bit acc;
      acc = (q.size() == 0) && in_valid_i;
      if (q.size() > 0 && !full_i) begin
        if (q[0].wrap) m_err = 1'b1;
        void'(q.pop_front());
      end
      if (acc) begin
        int lr, l1, l2, n;
        lr = tbl[in_rd_i]; l1 = tbl[in_rs1_i]; l2 = tbl[in_rs2_i];
        n = 1;
        if (lr > n) n = lr;
        if (l1 > n) n = l1;
        if (l2 > n) n = l2;
        for (int i = 0; i < n; i++) begin
          elem_t e;
          bit w0, w1, w2;
          e.op  = int'(in_op_i);
          e.rd  = stepped(int'(in_rd_i), lr, i, w0);
          e.rs1 = stepped(int'(in_rs1_i), l1, i, w1);
          e.rs2 = stepped(int'(in_rs2_i), l2, i, w2);
          e.wrap = w0 | w1 | w2;
          q.push_back(e);
        end
      end
      if (cfg_we_i) tbl[cfg_reg_i] = int'(cfg_len_i);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(push_o == (q.size() > 0), "R4", "push_o", push_o, q.size() > 0);
      chk(in_ready_o == (q.size() == 0), "R5", "in_ready_o", in_ready_o, q.size() == 0);
      chk(wrap_err_o == m_err, "R7", "wrap_err_o", wrap_err_o, m_err);
      if (push_o && q.size() > 0) begin
        chk(int'(out_op_o) == q[0].op, "R10", "op", out_op_o, q[0].op);
        chk(int'(out_rd_o) == q[0].rd, "R3", "rd", out_rd_o, q[0].rd);
        chk(int'(out_rs1_o) == q[0].rs1, "R3", "rs1", out_rs1_o, q[0].rs1);
        chk(int'(out_rs2_o) == q[0].rs2, "R2", "rs2", out_rs2_o, q[0].rs2);
      end
    end
  end

  // FIFO backpressure (R6)
  always @(negedge clk) full_i <= bp_on ? ($urandom % 3 == 0) : 1'b0;

  task automatic set_len(input int r, input int l);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_reg_i = REG_W'(r); cfg_len_i = LEN_W'(l);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic issue(input int op, input int rd, input int rs1, input int rs2);
    bit was;
    @(negedge clk);
    in_valid_i = 1'b1;
    in_op_i = OP_W'(op); in_rd_i = REG_W'(rd); in_rs1_i = REG_W'(rs1); in_rs2_i = REG_W'(rs2);
    do begin
      was = in_ready_o;
      @(negedge clk);
    end while (!was);
    in_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(in_ready_o == 1'b1, "R9", "in_ready_o", in_ready_o, 1);
    chk(push_o == 1'b0, "R9", "push_o", push_o, 0);
    chk(wrap_err_o == 1'b0, "R9", "wrap_err_o", wrap_err_o, 0);
    rst_ni = 1'b1;

    // R1 R9: all-scalar pass-through
    issue(5, 2, 4, 4);
    drain();
    // R1 R3: three-element expansion of r4, r2 scalar
    set_len(4, 3);
    issue(5, 2, 4, 4);
    drain();
    // R2: mixed lengths, rd vectorised shorter, rs2 scalar
    set_len(8, 2);
    issue(9, 8, 4, 20);
    drain();
    // back-to-back valid held high
    issue(3, 4, 8, 1);
    issue(4, 1, 1, 8);
    drain();
    // R6 under random backpressure
    bp_on = 1'b1;
    set_len(12, 15);
    issue(11, 12, 3, 12);
    issue(12, 4, 4, 4);
    drain();
    // R7 wrap
    set_len(30, 4);
    issue(6, 30, 2, 30);
    drain();
    // R8: rewrite mid-expansion, next instruction sees new entry
    issue(7, 2, 4, 4);
    set_len(4, 1);
    drain();
    issue(7, 2, 4, 4);
    drain();
    // R8: write and accept on the same edge uses the old entry
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_reg_i = 5'd4; cfg_len_i = 4'd5;
    in_valid_i = 1'b1; in_op_i = 7'd8; in_rd_i = 5'd4; in_rs1_i = 5'd0; in_rs2_i = 5'd0;
    @(negedge clk);
    cfg_we_i = 1'b0; in_valid_i = 1'b0;
    drain();
    issue(8, 4, 0, 0);
    drain();
    bp_on = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule